// File: doc/BRIEF.md
# Cascaded Dual Interrupt Controller

Two identical 8-input fixed-priority interrupt controller units are combined into one block. Together they serve 16 interrupt lines. The first unit (the primary) owns lines 0 to 7. The second unit (the secondary) owns lines 8 to 15 at local index line − 8. The secondary's interrupt output is wired to input 2 of the primary, so the processor sees a single interrupt output. The external line 2 is not connected to anything.

When the processor sees the interrupt, it pulses the acknowledge input for one cycle. On the following cycle the block presents an 8-bit vector, and it has updated the request and in-service state of the units involved.

- When the primary's winner is an ordinary line, only the primary takes part.
- When the primary's winner is the cascade input, the secondary picks its own winner under its own in-service level and its own special mask setting. Both units then mark the line in service.
- The handler must therefore end a secondary interrupt with an end-of-interrupt command to each unit.

Software reaches each unit through a command port and a data port. Through these it can:
- run the initialisation sequence;
- write and read the mask;
- read the pending or in-service register;
- switch special mask mode on and off;
- issue specific or non-specific end-of-interrupt commands.

Top module: `dual_pic_top`

## Requirements
- R1: After reset, int_o is 0 and vec_o is 0x00. The primary mask reads 0xF8 and the secondary mask reads 0xFE, so only lines 0, 1, 2 and 8 are enabled. The base vectors are 0x08 for the primary and 0x70 for the secondary, and the command port reads the pending register, which is 0x00.
- R2: Lines 0–7 belong to the primary and lines 8–15 to the secondary at local index line−8. An acknowledge of line L returns the owning unit's base plus the local index: 0x08+L for the primary and 0x70+(L−8) for the secondary under default bases.
- R3: Within a unit, a lower local index has higher priority. Across the cascade the overall order from highest to lowest is 0, 1, 8…15, 3…7. The acknowledge serves the highest-priority enabled pending line that is not blocked.
- R4: ack_i is a one-cycle pulse. vec_o takes its new value on the clock edge that samples ack_i and holds it until the next acknowledge.
- R5: Acknowledging a secondary line sets that line's in-service bit in the secondary and bit 2 in the primary. Line 2 cannot win again until end-of-interrupt commands have been given to both units: an end-of-interrupt to the secondary alone leaves int_o low.
- R6: The external input irq_i[2] is ignored. Raising it alone never asserts int_o and never sets primary pending bit 2.
- R7: The data port (addr_i[0]=1) writes and reads the unit's mask, with addr_i[1] selecting 0=primary or 1=secondary. A masked line never asserts int_o but stays pending, and unmasking it later asserts int_o. Masking primary bit 2 blocks all secondary lines.
- R8: While a line is in service, lines of lower or equal priority in the same unit do not assert int_o. Command 0x68 turns on special mask mode, in which any enabled pending line that is not in service may interrupt. Command 0x48 turns that mode off.
- R9: Command 0x20 (non-specific end of interrupt) clears the lowest-index in-service bit, and has no effect when none is set. Command 0x60|n (specific end of interrupt) clears in-service bit n.
- R10: If the primary has no line able to interrupt at acknowledge, vec_o is primary base+7. If the cascade input wins but the secondary has no line able to interrupt, vec_o is secondary base+7. In both cases no in-service bit is set.
- R11: A command write with bit 4 set starts initialisation and clears the mask, the in-service register, special mask mode and auto end-of-interrupt. The data writes that follow are taken in this order:
  - The first is the base, of which bits 7:3 are kept.
  - The next is the cascade byte, skipped when bit 1 of the initialisation byte is set.
  - The next is the mode byte, taken only when bit 0 of the initialisation byte is set. Its bit 1 selects auto end-of-interrupt, in which an acknowledge sets no in-service bit.
  - Later data writes are mask writes.
- R12: Command 0x0A selects the pending register and 0x0B selects the in-service register for reads of the command port (addr_i[0]=0).
- R13: A line request is latched when the line goes from low to high. Acknowledge clears the latched request, and lowering the line withdraws it. A line that is held high after acknowledge does not request again until it goes low and then high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_i | input | 16 | Interrupt lines; bit 2 unused |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Bit 1 selects the unit, bit 0 selects command (0) or data (1) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed port |
| ack_i | input | 1 | One-cycle acknowledge pulse |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector of the last acknowledge |

## Verification
A stale in-service bit, one set in the wrong unit, or a missing cascade bit shows up at the ports within a few cycles:
- int_o stays low after the end-of-interrupt sequence;
- int_o rises after only one end-of-interrupt;
- a port read of the in-service register is wrong;
- the vector after the next acknowledge is wrong.

A wrong priority order or a wrong pending latch shows up on the cycle after an acknowledge, as an unexpected vector. The pairwise sweep over all enabled lines exposes it for every pair.

// File: rtl/dpic_pkg.sv
package dpic_pkg;
  localparam int UNIT_LINES = 8;
  localparam int CASC_LINE  = 2;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_BASE,
    ST_CASC,
    ST_MODE
  } init_st_e;

  localparam int CMD_INIT_BIT = 4;
  localparam int CMD_SEL3_BIT = 3;
  localparam int CMD_EOI_BIT  = 5;
  localparam int CMD_SPEC_BIT = 6;
endpackage

// File: rtl/dpic_resolve.sv
module dpic_resolve #(
  parameter int LINES = 8,
  localparam int IW = $clog2(LINES)
) (
  input  logic [LINES-1:0] irr_i,
  input  logic [LINES-1:0] imr_i,
  input  logic [LINES-1:0] isr_i,
  input  logic             smm_i,
  output logic             int_o,
  output logic [IW-1:0]    win_o,
  output logic [IW:0]      lvl_o
);
  logic [LINES-1:0] elig;

  always_comb begin
    elig  = irr_i & ~imr_i & ~isr_i;
    win_o = '0;
    lvl_o = (IW+1)'(LINES);
    for (int i = LINES-1; i >= 0; i--) begin
      if (elig[i]) win_o = IW'(i);
      if (isr_i[i]) lvl_o = (IW+1)'(i);
    end
    int_o = (|elig) && (smm_i || ({1'b0, win_o} < lvl_o));
  end
endmodule

// File: rtl/dpic_unit.sv
module dpic_unit
  import dpic_pkg::*;
#(
  parameter int LINES = 8,
  parameter logic [LINES-1:0] RST_MASK = '1,
  parameter logic [7:0] RST_BASE = 8'h08,
  parameter logic [LINES-1:0] LEVEL_SET = '0,
  localparam int IW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_i,
  input  logic             wr_i,
  input  logic             a0_i,
  input  logic [7:0]       wdata_i,
  output logic [LINES-1:0] rdata_o,
  input  logic             ack_i,
  input  logic [IW-1:0]    ack_idx_i,
  output logic             int_o,
  output logic [IW-1:0]    win_o,
  output logic [7:0]       base_o
);
  localparam logic [7:0] BASE_KEEP = ~8'(LINES-1);

  logic [LINES-1:0] irr_q, irr_n, imr_q, imr_n, isr_q, isr_n, prev_q, prev_n;
  logic [7:0]       base_q, base_n;
  logic             smm_q, smm_n, rsel_q, rsel_n, aeoi_q, aeoi_n;
  logic             sngl_q, sngl_n, ic4_q, ic4_n;
  init_st_e         st_q, st_n;
  logic [IW:0]      lvl;

  dpic_resolve #(.LINES(LINES)) u_res (
    .irr_i(irr_q), .imr_i(imr_q), .isr_i(isr_q), .smm_i(smm_q),
    .int_o(int_o), .win_o(win_o), .lvl_o(lvl)
  );

  always_comb begin
    imr_n  = imr_q;
    isr_n  = isr_q;
    base_n = base_q;
    smm_n  = smm_q;
    rsel_n = rsel_q;
    aeoi_n = aeoi_q;
    sngl_n = sngl_q;
    ic4_n  = ic4_q;
    st_n   = st_q;
    prev_n = line_i;
    for (int i = 0; i < LINES; i++) begin
      if (LEVEL_SET[i]) irr_n[i] = line_i[i];
      else              irr_n[i] = line_i[i] & (irr_q[i] | ~prev_q[i]);
    end
    if (ack_i) begin
      irr_n[ack_idx_i] = 1'b0;
      if (!aeoi_q) isr_n[ack_idx_i] = 1'b1;
    end
    if (wr_i) begin
      if (!a0_i) begin
        if (wdata_i[CMD_INIT_BIT]) begin
          st_n   = ST_BASE;
          imr_n  = '0;
          isr_n  = '0;
          smm_n  = 1'b0;
          rsel_n = 1'b0;
          aeoi_n = 1'b0;
          sngl_n = wdata_i[1];
          ic4_n  = wdata_i[0];
        end else if (wdata_i[CMD_SEL3_BIT]) begin
          if (wdata_i[1]) rsel_n = wdata_i[0];
          if (wdata_i[6]) smm_n  = wdata_i[5];
        end else if (wdata_i[CMD_EOI_BIT]) begin
          if (wdata_i[CMD_SPEC_BIT]) isr_n[wdata_i[IW-1:0]] = 1'b0;
          else if (lvl < (IW+1)'(LINES)) isr_n[lvl[IW-1:0]] = 1'b0;
        end
      end else begin
        unique case (st_q)
          ST_RUN:  imr_n = wdata_i[LINES-1:0];
          ST_BASE: begin
            base_n = wdata_i & BASE_KEEP;
            if (!sngl_q)    st_n = ST_CASC;
            else if (ic4_q) st_n = ST_MODE;
            else            st_n = ST_RUN;
          end
          ST_CASC: st_n = ic4_q ? ST_MODE : ST_RUN;
          ST_MODE: begin
            aeoi_n = wdata_i[1];
            st_n   = ST_RUN;
          end
          default: st_n = ST_RUN;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= '0;
      imr_q  <= RST_MASK;
      isr_q  <= '0;
      prev_q <= '0;
      base_q <= RST_BASE;
      smm_q  <= 1'b0;
      rsel_q <= 1'b0;
      aeoi_q <= 1'b0;
      sngl_q <= 1'b0;
      ic4_q  <= 1'b0;
      st_q   <= ST_RUN;
    end else begin
      irr_q  <= irr_n;
      prev_q <= prev_n;
      isr_q  <= isr_n;
      if (wr_i) begin
        imr_q  <= imr_n;
        base_q <= base_n;
        smm_q  <= smm_n;
        rsel_q <= rsel_n;
        aeoi_q <= aeoi_n;
        sngl_q <= sngl_n;
        ic4_q  <= ic4_n;
        st_q   <= st_n;
      end
    end
  end

  assign rdata_o = a0_i ? imr_q : (rsel_q ? isr_q : irr_q);
  assign base_o  = base_q;

  // R13: an acknowledge only ever picks a line that is latched as pending
  p_ack_pending_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |-> irr_q[ack_idx_i]);
  // R5: in-service bits are only gained through an acknowledge
  p_isr_by_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr_q & ~$past(isr_q)) != '0) |-> $past(ack_i));
  // R5: at most one in-service bit is gained per cycle
  p_isr_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr_q & ~$past(isr_q)));
  // R7: a masked line is never acknowledged
  p_ack_unmasked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |-> !imr_q[ack_idx_i]);
endmodule

// File: rtl/dual_pic_top.sv
module dual_pic_top
  import dpic_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_i,
  input  logic        wr_i,
  input  logic [1:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic        ack_i,
  output logic        int_o,
  output logic [7:0]  vec_o
);
  localparam int LN = UNIT_LINES;
  localparam int IW = $clog2(LN);
  localparam logic [7:0] SPUR = 8'(LN-1);
  localparam logic [IW-1:0] CASC = IW'(CASC_LINE);

  logic [1:0]    rst_sync;
  logic          rst_s;
  logic [LN-1:0] m_line, s_line, m_rd, s_rd;
  logic          m_int, s_int, m_ack, s_ack;
  logic [IW-1:0] m_win, s_win;
  logic [7:0]    m_base, s_base, vec_q, vec_n;
  logic          unused_irq2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  assign unused_irq2 = irq_i[CASC_LINE];

  always_comb begin
    m_line = irq_i[LN-1:0];
    m_line[CASC] = s_int;
    s_line = irq_i[2*LN-1:LN];
  end

  dpic_unit #(.LINES(LN), .RST_MASK(8'hF8), .RST_BASE(8'h08),
              .LEVEL_SET(8'(1) << CASC_LINE)) u_pri (
    .clk(clk), .rst_n(rst_s), .line_i(m_line),
    .wr_i(wr_i && !addr_i[1]), .a0_i(addr_i[0]), .wdata_i(wdata_i),
    .rdata_o(m_rd), .ack_i(m_ack), .ack_idx_i(m_win),
    .int_o(m_int), .win_o(m_win), .base_o(m_base)
  );

  dpic_unit #(.LINES(LN), .RST_MASK(8'hFE), .RST_BASE(8'h70),
              .LEVEL_SET('0)) u_sec (
    .clk(clk), .rst_n(rst_s), .line_i(s_line),
    .wr_i(wr_i && addr_i[1]), .a0_i(addr_i[0]), .wdata_i(wdata_i),
    .rdata_o(s_rd), .ack_i(s_ack), .ack_idx_i(s_win),
    .int_o(s_int), .win_o(s_win), .base_o(s_base)
  );

  always_comb begin
    m_ack = 1'b0;
    s_ack = 1'b0;
    vec_n = vec_q;
    if (ack_i) begin
      if (!m_int) begin
        vec_n = m_base + SPUR;
      end else if (m_win != CASC) begin
        m_ack = 1'b1;
        vec_n = m_base + 8'(m_win);
      end else if (s_int) begin
        m_ack = 1'b1;
        s_ack = 1'b1;
        vec_n = s_base + 8'(s_win);
      end else begin
        vec_n = s_base + SPUR;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)     vec_q <= 8'h00;
    else if (ack_i) vec_q <= vec_n;
  end

  assign vec_o   = vec_q;
  assign int_o   = m_int;
  assign rdata_o = addr_i[1] ? s_rd : m_rd;

  // R5: the secondary is only acknowledged when the primary's winner is the cascade input
  p_casc_path_r5: assert property (@(posedge clk) disable iff (!rst_s)
    s_ack |-> (m_int && m_win == CASC));
  // R2: every vector lies in the block of one unit's base
  p_vec_owner_r2: assert property (@(posedge clk) disable iff (!rst_s)
    $past(ack_i) |-> (vec_o[7:3] == $past(m_base[7:3]) || vec_o[7:3] == $past(s_base[7:3])));
  // R4: the vector holds between acknowledges
  p_vec_hold_r4: assert property (@(posedge clk) disable iff (!rst_s)
    !$past(ack_i) |-> $stable(vec_o));
endmodule

// File: tb/sim_dual_pic_top.sv
`timescale 1ns/1ps
module sim_dual_pic_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq = '0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'b00;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        ack = 1'b0;
  logic        intr;
  logic [7:0]  vec;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  dual_pic_top u0 (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ack_i(ack), .int_o(intr), .vec_o(vec)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrp(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rdp(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic do_ack();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic eoi(input int l);
    if (l >= 8) wrp(2'b10, 8'h20);
    wrp(2'b00, 8'h20);
  endtask

  function automatic int vecof(input int l);
    return (l < 8) ? (8'h08 + l) : (8'h70 + l - 8);
  endfunction

  function automatic int rank(input int l);
    return (l < 2) ? l : ((l >= 8) ? l - 6 : l + 8);
  endfunction

  initial begin
    logic [7:0] d;
    int first, second;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R1: reset state
    chk("R1 int", intr, 0);
    chk("R1 vec", vec, 8'h00);
    rdp(2'b01, d); chk("R1 primary mask", d, 8'hF8);
    rdp(2'b11, d); chk("R1 secondary mask", d, 8'hFE);
    rdp(2'b00, d); chk("R1 primary pending", d, 8'h00);

    // R10: nothing pending gives primary spurious vector
    do_ack();
    chk("R10 primary spurious", vec, 8'h0F);

    // R7: masking and unmasking
    irq[4] = 1'b1; cyc(4);
    chk("R7 masked line no int", intr, 0);
    rdp(2'b00, d); chk("R7 masked still pending", d, 8'h10);
    wrp(2'b01, 8'h00); wrp(2'b11, 8'h00); cyc(2);
    chk("R7 unmask asserts int", intr, 1);
    do_ack(); chk("R7 vector line 4", vec, 8'h0C);
    eoi(4); irq[4] = 1'b0; cyc(3);
    wrp(2'b01, 8'h04);
    irq[9] = 1'b1; cyc(4);
    chk("R7 cascade mask blocks secondary", intr, 0);
    wrp(2'b01, 8'h00); cyc(2);
    chk("R7 cascade unmask", intr, 1);
    do_ack(); chk("R7 vector line 9", vec, 8'h71);
    eoi(9); irq[9] = 1'b0; cyc(4);

    // R6: external line 2 is ignored
    @(negedge clk); irq[2] = 1'b1; cyc(5);
    chk("R6 line 2 no int", intr, 0);
    rdp(2'b00, d); chk("R6 primary pending bit 2", d, 8'h00);
    @(negedge clk); irq[2] = 1'b0;

    // R2 R4 R13: each line alone
    for (int l = 0; l < 16; l++) begin
      if (l != 2) begin
        @(negedge clk); irq[l] = 1'b1; cyc(4);
        chk($sformatf("R2 int line %0d", l), intr, 1);
        do_ack();
        chk($sformatf("R2 vector line %0d", l), vec, vecof(l));
        cyc(2);
        chk($sformatf("R4 vector held line %0d", l), vec, vecof(l));
        eoi(l); cyc(4);
        chk($sformatf("R13 held line %0d no re-request", l), intr, 0);
        @(negedge clk); irq[l] = 1'b0; cyc(3);
      end
    end
    @(negedge clk); irq[0] = 1'b1; cyc(4);
    chk("R13 new edge requests again", intr, 1);
    @(negedge clk); irq[0] = 1'b0; cyc(3);
    chk("R13 lowering withdraws", intr, 0);

    // R3: every pair of lines raised together
    for (int a = 0; a < 16; a++) begin
      for (int b = a + 1; b < 16; b++) begin
        if (a != 2 && b != 2) begin
          first  = (rank(a) < rank(b)) ? a : b;
          second = (first == a) ? b : a;
          @(negedge clk); irq[a] = 1'b1; irq[b] = 1'b1; cyc(4);
          do_ack();
          chk($sformatf("R3 pair %0d,%0d first", a, b), vec, vecof(first));
          eoi(first); cyc(4);
          chk($sformatf("R3 pair %0d,%0d second int", a, b), intr, 1);
          do_ack();
          chk($sformatf("R3 pair %0d,%0d second", a, b), vec, vecof(second));
          eoi(second);
          @(negedge clk); irq[a] = 1'b0; irq[b] = 1'b0; cyc(4);
          chk($sformatf("R3 pair %0d,%0d idle", a, b), intr, 0);
        end
      end
    end

    // R5: both end-of-interrupt commands needed
    @(negedge clk); irq[9] = 1'b1; irq[10] = 1'b1; cyc(4);
    do_ack(); chk("R5 vector line 9", vec, 8'h71);
    wrp(2'b00, 8'h0B);
    rdp(2'b00, d); chk("R5 primary in-service", d, 8'h04);
    wrp(2'b10, 8'h0B);
    rdp(2'b10, d); chk("R5 secondary in-service", d, 8'h02);
    wrp(2'b10, 8'h20); cyc(4);
    chk("R5 one EOI keeps int low", intr, 0);
    wrp(2'b00, 8'h20); cyc(4);
    chk("R5 both EOIs int high", intr, 1);
    do_ack(); chk("R5 vector line 10", vec, 8'h72);
    eoi(10);
    rdp(2'b00, d); chk("R5 primary in-service cleared", d, 8'h00);
    wrp(2'b00, 8'h0A); wrp(2'b10, 8'h0A);
    @(negedge clk); irq[9] = 1'b0; irq[10] = 1'b0; cyc(4);

    // R8 R9 R12: in-service blocking, special mask, EOI forms
    @(negedge clk); irq[3] = 1'b1; cyc(4);
    do_ack(); chk("R8 vector line 3", vec, 8'h0B);
    @(negedge clk); irq[5] = 1'b1; cyc(4);
    chk("R8 lower priority blocked", intr, 0);
    wrp(2'b00, 8'h68); cyc(2);
    chk("R8 special mask lets through", intr, 1);
    do_ack(); chk("R8 vector line 5", vec, 8'h0D);
    wrp(2'b00, 8'h48);
    wrp(2'b00, 8'h0B);
    rdp(2'b00, d); chk("R12 in-service read", d, 8'h28);
    wrp(2'b00, 8'h20);
    rdp(2'b00, d); chk("R9 non-specific clears lowest", d, 8'h20);
    wrp(2'b00, 8'h65);
    rdp(2'b00, d); chk("R9 specific clears bit 5", d, 8'h00);
    wrp(2'b00, 8'h20);
    rdp(2'b00, d); chk("R9 empty EOI no effect", d, 8'h00);
    wrp(2'b00, 8'h0A);
    rdp(2'b00, d); chk("R12 pending read", d, 8'h00);
    @(negedge clk); irq[3] = 1'b0; irq[5] = 1'b0; cyc(3);

    // R10: cascade wins with no secondary request left
    @(negedge clk); irq[9] = 1'b1; cyc(4);
    @(negedge clk); irq[9] = 1'b0;
    do_ack();
    chk("R10 secondary spurious", vec, 8'h77);
    wrp(2'b00, 8'h0B);
    rdp(2'b00, d); chk("R10 primary no in-service", d, 8'h00);
    wrp(2'b10, 8'h0B);
    rdp(2'b10, d); chk("R10 secondary no in-service", d, 8'h00);
    cyc(3);

    // R11: initialisation sequences
    wrp(2'b00, 8'h11); wrp(2'b01, 8'h20); wrp(2'b01, 8'h04); wrp(2'b01, 8'h03);
    rdp(2'b01, d); chk("R11 init clears mask", d, 8'h00);
    wrp(2'b10, 8'h13); wrp(2'b11, 8'h78); wrp(2'b11, 8'h01);
    wrp(2'b11, 8'h02);
    rdp(2'b11, d); chk("R11 single skips cascade byte", d, 8'h02);
    wrp(2'b11, 8'h00);
    @(negedge clk); irq[0] = 1'b1; cyc(4);
    do_ack(); chk("R11 new primary base", vec, 8'h20);
    wrp(2'b00, 8'h0B);
    rdp(2'b00, d); chk("R11 auto EOI no in-service", d, 8'h00);
    @(negedge clk); irq[0] = 1'b0; irq[9] = 1'b1; cyc(4);
    do_ack(); chk("R11 new secondary base", vec, 8'h79);
    wrp(2'b10, 8'h0B);
    rdp(2'b10, d); chk("R11 secondary normal EOI mode", d, 8'h02);
    wrp(2'b10, 8'h20);
    rdp(2'b10, d); chk("R11 secondary EOI", d, 8'h00);
    @(negedge clk); irq[9] = 1'b0; cyc(4);
    chk("R11 idle at end", intr, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule